// File: doc/BRIEF.md
# Sequential Matrix Dot-Product Engine

This block works out the dot product of a short vector held in a register bank with a run of signed 16-bit words read from memory. Each 32-bit register in the bank holds two vector elements. A start pulse supplies three things: a control field that sets the element count and the memory walk order, a base register index, and a start byte address. The engine then issues one memory read per cycle and multiplies each returned word by the matching vector element. It adds the product to a wide accumulator.

The memory is modelled as a simple read port with one cycle of latency. The engine has no instruction decode and does not update any flags. It ends each operation with a one-cycle done pulse. At that point the low 32 bits of the sum are on the result port, and they stay there until the next start is accepted.

Top module: `mmac_unit`

## Requirements
- R1: The element count N is `ctrl_i[3:0]` (0 to 15), and the result is the sum of exactly N products.
- R2: Element i is read from bank register `(base_i + i/2) mod 16`. An even i takes bits [31:16] of that register and an odd i takes bits [15:0].
- R3: Each product treats both the vector element and the memory word as signed 16-bit two's-complement values.
- R4: When `ctrl_i[4]` is 0 (row walk), element i is read from byte address `ptr_i + 2*i`, modulo 2^16.
- R5: When `ctrl_i[4]` is 1 (column walk), element i is read from byte address `ptr_i + 2*N*i`, modulo 2^16.
- R6: The accumulator is at least 36 bits wide, and `result_o` carries the low 32 bits of the exact sum.
- R7: A count of 0 issues no memory read. It raises `done_o` one cycle after the accepting edge, with `result_o` equal to 0.
- R8: A start is accepted on a rising edge when `start_i` is high and `busy_o` is low. `mem_req_o` is then high for exactly N consecutive cycles, beginning in the cycle after that edge. `done_o` is a one-cycle pulse that appears after the (N+1)-th rising edge following the accepting edge, and `busy_o` is low in that same cycle.
- R9: `start_i` and the other operand inputs are ignored while `busy_o` is high.
- R10: After reset, `busy_o`, `done_o`, `mem_req_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| ctrl_i | input | 5 | [3:0] element count, [4] column walk |
| ptr_i | input | 16 | Start byte address of the matrix data |
| base_i | input | 4 | First bank register of the vector |
| vreg_idx_o | output | 4 | Bank register index being read |
| vreg_data_i | input | 32 | Content of the indexed bank register |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read byte address |
| mem_rdata_i | input | 16 | Read data, one cycle after the request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Low 32 bits of the accumulated sum |

## Verification
The bench runs a full count of 15 in which every element and word is -32768. The exact sum then goes above 2^32, so an accumulator that saturates or drops high bits before truncation would return the wrong low word. Other directed cases cover a base index of 15, where the vector must wrap to register 0 (an unwrapped index would read the wrong register), and a count of 0, which must finish with no read at all. Column-walk runs whose address passes 0xFFFF catch a stride built from the wrong count or the wrong width. Runs that hold `start_i` high during an operation and change the operands show whether the engine would restart, or latch a new count, partway through.

// File: rtl/mmac_pkg.sv
package mmac_pkg;
  localparam int ELEM_W = 16;
  localparam int REG_W  = 2 * ELEM_W;
  localparam int RES_W  = 32;

  typedef logic signed [ELEM_W-1:0] elem_t;
  typedef logic signed [REG_W-1:0]  prod_t;
endpackage

// File: rtl/mmac_addr_gen.sv
module mmac_addr_gen #(
  parameter int AW    = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             col_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [AW-1:0]    ptr_i,
  input  logic             adv_i,
  output logic [AW-1:0]    addr_o
);
  logic [AW-1:0] addr_q, stride_q, stride_d;
  logic          col_q;
  logic [CNT_W-1:0] cnt_q;

  assign stride_d = col_i ? AW'({cnt_i, 1'b0}) : AW'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      stride_q <= '0;
      col_q    <= 1'b0;
      cnt_q    <= '0;
    end else if (load_i) begin
      addr_q   <= ptr_i;
      stride_q <= stride_d;
      col_q    <= col_i;
      cnt_q    <= cnt_i;
    end else if (adv_i) begin
      addr_q <= addr_q + stride_q;
    end
  end

  assign addr_o = addr_q;

  p_row_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !col_q) |=> (addr_q == $past(addr_q) + AW'(2)));

  p_col_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && col_q) |=> (addr_q == $past(addr_q) + AW'({cnt_q, 1'b0})));
endmodule

// File: rtl/mmac_elem_sel.sv
module mmac_elem_sel
  import mmac_pkg::*;
#(
  parameter int RIDX_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic [RIDX_W-1:0] base_i,
  input  logic [CNT_W-1:0]  idx_i,
  output logic [RIDX_W-1:0] reg_idx_o,
  input  logic [REG_W-1:0]  reg_data_i,
  output elem_t             elem_o
);
  logic [CNT_W-1:0] pair;

  assign pair      = idx_i >> 1;
  assign reg_idx_o = base_i + RIDX_W'(pair);
  // even element in the upper half
  assign elem_o    = idx_i[0] ? reg_data_i[ELEM_W-1:0] : reg_data_i[REG_W-1:ELEM_W];
endmodule

// File: rtl/mmac_accum.sv
module mmac_accum
  import mmac_pkg::*;
#(
  parameter int ACC_W = 36
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             add_i,
  input  elem_t            a_i,
  input  elem_t            b_i,
  output logic [ACC_W-1:0] acc_o
);
  localparam int EXT_W = ACC_W - REG_W;

  prod_t            prod;
  logic [ACC_W-1:0] prod_ext, acc_q;

  assign prod     = a_i * b_i;
  assign prod_ext = {{EXT_W{prod[REG_W-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (add_i)   acc_q <= acc_q + prod_ext;
  end

  assign acc_o = acc_q;

  p_acc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !add_i) |=> $stable(acc_q));
endmodule

// File: rtl/mmac_unit.sv
module mmac_unit
  import mmac_pkg::*;
#(
  parameter int AW     = 16,
  parameter int RIDX_W = 4,
  parameter int CNT_W  = 4,
  parameter int ACC_W  = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W:0]    ctrl_i,
  input  logic [AW-1:0]     ptr_i,
  input  logic [RIDX_W-1:0] base_i,
  output logic [RIDX_W-1:0] vreg_idx_o,
  input  logic [REG_W-1:0]  vreg_data_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [ELEM_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o
);
  logic              busy_q, issuing_q, vld_q, done_q;
  logic [CNT_W-1:0]  idx_q, cnt_q;
  logic [RIDX_W-1:0] base_q;
  elem_t             elem_w, elem_q;
  logic [ACC_W-1:0]  acc;
  logic              accept, finish, last_issue;

  assign accept     = start_i && !busy_q;
  assign finish     = busy_q && !issuing_q;
  assign last_issue = issuing_q && (idx_q == cnt_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      issuing_q <= 1'b0;
      done_q    <= 1'b0;
      idx_q     <= '0;
      cnt_q     <= '0;
      base_q    <= '0;
    end else if (accept) begin
      busy_q    <= 1'b1;
      issuing_q <= |ctrl_i[CNT_W-1:0];
      done_q    <= 1'b0;
      idx_q     <= '0;
      cnt_q     <= ctrl_i[CNT_W-1:0];
      base_q    <= base_i;
    end else begin
      done_q <= finish;
      if (finish) busy_q <= 1'b0;
      if (issuing_q) begin
        idx_q <= idx_q + CNT_W'(1);
        if (last_issue) issuing_q <= 1'b0;
      end
    end
  end

  // align vector element with the read data one cycle later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      elem_q <= '0;
    end else begin
      vld_q <= issuing_q;
      if (issuing_q) elem_q <= elem_w;
    end
  end

  mmac_elem_sel #(.RIDX_W(RIDX_W), .CNT_W(CNT_W)) u_sel (
    .base_i     (base_q),
    .idx_i      (idx_q),
    .reg_idx_o  (vreg_idx_o),
    .reg_data_i (vreg_data_i),
    .elem_o     (elem_w)
  );

  mmac_addr_gen #(.AW(AW), .CNT_W(CNT_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .col_i  (ctrl_i[CNT_W]),
    .cnt_i  (ctrl_i[CNT_W-1:0]),
    .ptr_i  (ptr_i),
    .adv_i  (issuing_q),
    .addr_o (mem_addr_o)
  );

  mmac_accum #(.ACC_W(ACC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .add_i   (vld_q),
    .a_i     (elem_q),
    .b_i     (elem_t'(mem_rdata_i)),
    .acc_o   (acc)
  );

  assign mem_req_o = issuing_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign result_o  = acc[RES_W-1:0];

  p_req_in_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_zero_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && ctrl_i[CNT_W-1:0] == '0) |=> !mem_req_o ##1 (done_o && result_o == '0));

  p_hold_cfg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(cnt_q) && $stable(base_q)));
endmodule

// File: tb/mmac_unit_bench.sv
module mmac_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  ctrl = '0;
  logic [15:0] ptr = '0;
  logic [3:0]  base = '0;
  logic [3:0]  vreg_idx;
  logic [31:0] vreg_data;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        busy, done;
  logic [31:0] result;

  logic [15:0] mem  [256];
  logic [31:0] bank [16];

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mmac_unit u_mmac_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ctrl_i(ctrl), .ptr_i(ptr),
    .base_i(base), .vreg_idx_o(vreg_idx), .vreg_data_i(vreg_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  assign vreg_data = bank[vreg_idx];
  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[8:1]];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic logic [15:0] exp_addr(input logic [4:0] c, input logic [15:0] p, input int i);
    int stride = c[4] ? 2 * int'(c[3:0]) : 2;
    return 16'(int'(p) + i * stride);
  endfunction

  function automatic logic [31:0] exp_result(input logic [4:0] c, input logic [3:0] b, input logic [15:0] p);
    longint sum = 0;
    for (int i = 0; i < int'(c[3:0]); i++) begin
      logic [15:0] a = exp_addr(c, p, i);
      logic [31:0] r = bank[4'(int'(b) + i / 2)];
      logic signed [15:0] e = (i % 2 == 0) ? r[31:16] : r[15:0];
      logic signed [15:0] w = mem[a[8:1]];
      sum += longint'(e) * longint'(w);
    end
    return sum[31:0];
  endfunction

  task automatic run_op(input logic [4:0] c, input logic [3:0] b, input logic [15:0] p, input bit poke);
    int n = int'(c[3:0]);
    int nreq = 0;
    int bad_addr = 0;
    int done_k = -1;
    logic [31:0] exp_r = exp_result(c, b, p);
    logic [31:0] got_r = '0;
    string areq = c[4] ? "R5 col address" : "R4 row address";
    @(negedge clk);
    start = 1'b1; ctrl = c; base = b; ptr = p;
    @(negedge clk);
    if (poke) begin
      ctrl = ~c; base = ~b; ptr = ~p;
    end else start = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (mem_req) begin
        if (nreq >= n || mem_addr != exp_addr(c, p, nreq)) bad_addr++;
        nreq++;
      end
      if (done) begin
        done_k = k;
        got_r  = result;
        chk(!busy, "R8 busy low with done", busy, 0);
        break;
      end
      if (k >= n) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(bad_addr == 0, areq, bad_addr, 0);
    chk(nreq == n, "R8/R1 request count", nreq, n);
    chk(done_k == n + 1, "R8 done cycle", done_k, n + 1);
    chk(got_r == exp_r, poke ? "R9 result with start held" : "R1/R2/R3/R6 result", got_r, exp_r);
    @(negedge clk);
    chk(!done, "R8 done single pulse", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    for (int i = 0; i < 16; i++) bank[i] = $urandom;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && result == 0, "R10 reset state",
        {busy, done, mem_req, |result}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req && result == 0, "R10 idle after release",
        {busy, done, mem_req, |result}, 0);

    // R7 zero count, both walk modes
    run_op(5'h00, 4'd3, 16'h0010, 1'b0);
    run_op(5'h10, 4'd3, 16'h0010, 1'b0);

    // R3/R6 all -32768: exact sum beyond 32 bits
    for (int i = 0; i < 256; i++) mem[i] = 16'h8000;
    for (int i = 0; i < 16; i++) bank[i] = 32'h8000_8000;
    run_op(5'h0F, 4'd0, 16'h0000, 1'b0);
    run_op(5'h1F, 4'd9, 16'h0100, 1'b0);
    chk(result == 32'hC000_0000, "R6 low word of 15*2^30", result, 32'hC000_0000);

    // R3 mixed signs, R2 half order and bank wrap from register 15
    for (int i = 0; i < 256; i++) mem[i] = (i % 2 == 0) ? 16'hFFFF : 16'h0003;
    for (int i = 0; i < 16; i++) bank[i] = {16'(i + 1), 16'(-(i + 1))};
    run_op(5'h04, 4'd15, 16'h0000, 1'b0);
    // pairs: reg15 (16,-16), reg0 (1,-1) -> -16 -48 -1 -3 = -68
    chk(result == 32'hFFFF_FFBC, "R2/R3 wrap and half order", result, 32'hFFFF_FFBC);
    run_op(5'h01, 4'd7, 16'h0002, 1'b0);

    // R9 start held with changed operands during operation
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    for (int i = 0; i < 16; i++) bank[i] = $urandom;
    run_op(5'h06, 4'd2, 16'h0040, 1'b1);
    run_op(5'h1B, 4'd12, 16'hFFF0, 1'b1);

    // R5 column walk crossing the top of the address space
    run_op(5'h1F, 4'd1, 16'hFF80, 1'b0);

    for (int t = 0; t < 80; t++) begin
      logic [4:0]  rc = 5'($urandom);
      logic [3:0]  rb = 4'($urandom);
      logic [15:0] rp = 16'($urandom) & 16'hFFFE;
      run_op(rc, rb, rp, ($urandom % 4) == 0);
    end

    summary();
    $finish;
  end
endmodule